// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a lower-level memory. The processor presents one 32-bit word access at a time. The block splits the byte address into three fields: tag, line index and block offset. Each line holds a valid flag, a modified flag, a stored tag and a block of several words. A hit is served combinationally. A load returns its word in the same cycle, and a store updates the line at the next clock edge without going to memory.

On a miss the block raises a stall and keeps it high until the access has been served. If the indexed line holds modified data, that whole block is first sent to memory. The requested block is then read back in. On the cycle the refill data arrives, the line is installed. A load gets its word directly from the arriving block. A store merges its word into the arriving block and leaves the line marked modified. Both block transfers use a single request/acknowledge port that moves one full block per request.

The processor keeps its request, write flag, address and write data steady while the stall is high. An access completes on the first rising edge at which the request is high and the stall is low.

Top module: `dcache_wb`

## Requirements
- R1: The byte address is split into three fields. The offset is bits [3:0], and bits [3:2] select the word within the block, with word w held at block bits [32w+31:32w]. The index is bits [11:4] and selects one of 256 lines. The tag is bits [31:12].
- R2: `cpu_hit` is high only when a request is present, the controller is idle, the indexed line is valid and its stored tag equals the address tag. A request that hits is never stalled.
- R3: A store that hits writes only its word into the line and marks the line modified. It starts no memory transfer.
- R4: A store that misses fetches the block from memory, merges the store word into it, and leaves the line valid and modified.
- R5: Any miss raises `cpu_stall` in the cycle the request appears. If the victim line is modified, it is written to memory at its own block address before the refill read. A clean victim is dropped with no memory write.
- R6: When a refill completes, the line becomes valid with the address tag. The next access to the same block hits.
- R7: For a load miss, the requested word appears on `cpu_rdata` in the cycle in which `mem_ack` accepts the refill read. `cpu_stall` is low in that same cycle.
- R8: After reset every line is invalid and unmodified, `cpu_stall` and `mem_req` are low, and the first access to any address misses.
- R9: The memory port carries one whole block per request. `mem_addr` is block-aligned with its low four bits zero, `mem_we` is 1 for a write-back and 0 for a refill, and `mem_req`, `mem_we` and `mem_addr` stay steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data |
| cpu_hit | output | 1 | Current request hits |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory transfer request (valid) |
| mem_we | output | 1 | 1 for a block write-back, 0 for a refill read |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_wdata | output | 128 | Victim block sent to memory |
| mem_ack | input | 1 | Memory accepts or completes the transfer (ready) |
| mem_rdata | input | 128 | Refill block from memory, valid with `mem_ack` |

## Verification
The bench runs four access patterns. Repeated loads and stores to one block separate hits from misses and show that word selection follows the offset bits. Alternating tags on a single index separate a dirty victim, which must produce a write-back carrying the stored word, from a clean victim, which must produce no memory write. Stores to blocks that are not cached show the refill-and-merge path and the modified flag that it leaves. A sweep over several indices, first with stores and then with conflicting loads, shows that lines are kept apart and that every evicted block leaves at its own address with its latest contents.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [1:0] {
    DC_IDLE   = 2'd0,
    DC_EVICT  = 2'd1,
    DC_REFILL = 2'd2
  } dc_state_e;

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int LINES = 256,
  parameter int IDX_W = 8,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic             mark_dirty
);

  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q [LINES];

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_q[idx];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (fill_en) begin
      valid_d[idx] = 1'b1;
      dirty_d[idx] = fill_dirty;
    end else if (mark_dirty) begin
      dirty_d[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx] <= fill_tag;
    end
  end

  // R6: an installed line is valid and carries the new tag
  assert_fill_installs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(idx)] && (tag_q[$past(idx)] == $past(fill_tag)));

  // R4: a refill for a store leaves the line modified
  assert_store_fill_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_dirty) |=> dirty_q[$past(idx)]);

  // R3: a store hit marks the line modified
  assert_hit_store_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_dirty && !fill_en) |=> dirty_q[$past(idx)]);

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int LINES = 256,
  parameter int IDX_W = 8,
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  output logic [BLK_W-1:0] rd_line,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_line
);

  logic [BLK_W-1:0] line_q [LINES];

  assign rd_line = line_q[idx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_q[idx] <= wr_line;
    end
  end

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dcache_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cpu_req,
  input  logic      cpu_we,
  input  logic      tag_match,
  input  logic      victim_dirty,
  input  logic      mem_ack,
  output dc_state_e state,
  output logic      cpu_hit,
  output logic      cpu_stall,
  output logic      mem_req,
  output logic      mem_we,
  output logic      fill_done,
  output logic      hit_write
);

  dc_state_e state_q, state_d;

  assign state = state_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      DC_IDLE: begin
        if (cpu_req && !tag_match) begin
          state_d = victim_dirty ? DC_EVICT : DC_REFILL;
        end
      end
      DC_EVICT: begin
        if (mem_ack) state_d = DC_REFILL;
      end
      DC_REFILL: begin
        if (mem_ack) state_d = DC_IDLE;
      end
      default: state_d = DC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DC_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    cpu_hit   = cpu_req && (state_q == DC_IDLE) && tag_match;
    fill_done = (state_q == DC_REFILL) && mem_ack;
    hit_write = cpu_hit && cpu_we;
    cpu_stall = cpu_req && !cpu_hit && !fill_done;
    mem_req   = (state_q == DC_EVICT) || (state_q == DC_REFILL);
    mem_we    = (state_q == DC_EVICT);
  end

  // R9: a memory request stays up and unchanged in kind until accepted
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_we));

  // R5: an accepted write-back is always followed by a refill read
  assert_wb_then_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> mem_req && !mem_we);

  // R5: a missing request in the idle state is stalled
  assert_miss_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !tag_match && state_q == DC_IDLE) |-> cpu_stall);

  // R2: a hit is never stalled
  assert_hit_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> !cpu_stall);

endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import dcache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int LINES       = 256,
  parameter int BLOCK_BYTES = 16
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       cpu_req,
  input  logic                                       cpu_we,
  input  logic [ADDR_W-1:0]                          cpu_addr,
  input  logic [WORD_W-1:0]                          cpu_wdata,
  output logic [WORD_W-1:0]                          cpu_rdata,
  output logic                                       cpu_hit,
  output logic                                       cpu_stall,
  output logic                                       mem_req,
  output logic                                       mem_we,
  output logic [ADDR_W-1:0]                          mem_addr,
  output logic [BLOCK_BYTES*8-1:0]                   mem_wdata,
  input  logic                                       mem_ack,
  input  logic [BLOCK_BYTES*8-1:0]                   mem_rdata
);

  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WPB    = BLOCK_BYTES / (WORD_W / 8);
  localparam int WSEL_W = $clog2(WPB);
  localparam int BLK_W  = BLOCK_BYTES * 8;
  localparam int BYTE_W = OFF_W - WSEL_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // address fields
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WSEL_W-1:0] a_wsel;
  logic              unused_byte_bits;

  assign a_tag  = cpu_addr[ADDR_W-1:OFF_W+IDX_W];
  assign a_idx  = cpu_addr[OFF_W+IDX_W-1:OFF_W];
  assign a_wsel = cpu_addr[OFF_W-1:BYTE_W];
  assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  // line state
  logic             l_valid, l_dirty;
  logic [TAG_W-1:0] l_tag;
  logic [BLK_W-1:0] l_data;
  logic             tag_match;
  dc_state_e        st;
  logic             fill_done, hit_write;

  assign tag_match = l_valid && (l_tag == a_tag);

  dc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .tag_match    (tag_match),
    .victim_dirty (l_valid && l_dirty),
    .mem_ack      (mem_ack),
    .state        (st),
    .cpu_hit      (cpu_hit),
    .cpu_stall    (cpu_stall),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .fill_done    (fill_done),
    .hit_write    (hit_write)
  );

  dc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .idx        (a_idx),
    .line_valid (l_valid),
    .line_dirty (l_dirty),
    .line_tag   (l_tag),
    .fill_en    (fill_done),
    .fill_tag   (a_tag),
    .fill_dirty (cpu_we),
    .mark_dirty (hit_write)
  );

  // merge path: base block is the refill data or the resident line
  logic [BLK_W-1:0] base_blk, merged_blk;
  assign base_blk = fill_done ? mem_rdata : l_data;

  for (genvar w = 0; w < WPB; w++) begin : g_merge
    always_comb begin
      if (cpu_we && (a_wsel == WSEL_W'(w)))
        merged_blk[w*WORD_W +: WORD_W] = cpu_wdata;
      else
        merged_blk[w*WORD_W +: WORD_W] = base_blk[w*WORD_W +: WORD_W];
    end
  end

  dc_data_store #(.LINES(LINES), .IDX_W(IDX_W), .BLK_W(BLK_W)) u_data (
    .clk     (clk),
    .idx     (a_idx),
    .rd_line (l_data),
    .wr_en   (fill_done || hit_write),
    .wr_line (merged_blk)
  );

  assign cpu_rdata = base_blk[int'(a_wsel)*WORD_W +: WORD_W];
  assign mem_wdata = l_data;
  assign mem_addr  = {((st == DC_EVICT) ? l_tag : a_tag), a_idx, {OFF_W{1'b0}}};

  // R9: block-aligned address held steady while a transfer waits
  assert_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mem_req && !mem_ack) |=> $stable(mem_addr) && (mem_addr[OFF_W-1:0] == '0));

  // R8: no stall and no memory traffic without a request right after reset
  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!cpu_req && !mem_req) |-> !cpu_stall);

endmodule

// File: tb/sim_dcache_wb.sv
`timescale 1ns/1ps
module sim_dcache_wb;

  logic         clk, rst_n;
  logic         cpu_req, cpu_we;
  logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
  logic         cpu_hit, cpu_stall;
  logic         mem_req, mem_we, mem_ack;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata;

  dcache_wb u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int wb_seen = 0;
  int wb_exp = 0;
  logic [31:0] exp_wb_addr;

  // reference state built from the requirements
  logic        ref_valid [256];
  logic        ref_dirty [256];
  logic [19:0] ref_tag   [256];
  logic [31:0]  ref_word [int unsigned];
  logic [127:0] mem_blk  [int unsigned];
  logic [31:0]  sb_q [$];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  function automatic logic [31:0] ref_rd(input logic [31:0] wa);
    if (ref_word.exists(wa)) return ref_word[wa];
    return init_word(wa);
  endfunction

  function automatic logic [127:0] ref_blk(input logic [31:0] ba);
    logic [127:0] b;
    for (int w = 0; w < 4; w++) b[w*32 +: 32] = ref_rd({ba[31:4], w[1:0], 2'b00});
    return b;
  endfunction

  function automatic logic [127:0] mem_get(input logic [31:0] ba);
    logic [127:0] b;
    if (mem_blk.exists(ba[31:4])) return mem_blk[ba[31:4]];
    for (int w = 0; w < 4; w++) b[w*32 +: 32] = init_word({ba[31:4], w[1:0], 2'b00});
    return b;
  endfunction

  // memory responder (R9 alignment, R5 write-back content)
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (wait_cnt < 2) begin
          wait_cnt++;
        end else begin
          wait_cnt = 0;
          chk(mem_addr[3:0] == 4'h0, "R9 block aligned", mem_addr, {mem_addr[31:4], 4'h0});
          if (mem_we) begin
            wb_seen++;
            chk(mem_addr == exp_wb_addr, "R5 victim address", mem_addr, exp_wb_addr);
            chk(mem_wdata == ref_blk(mem_addr), "R5 victim data", mem_wdata, ref_blk(mem_addr));
            mem_blk[mem_addr[31:4]] = mem_wdata;
          end else begin
            mem_rdata = mem_get(mem_addr);
          end
          mem_ack = 1'b1;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  // scoreboard monitor: load results against queued expectations (R1, R7)
  initial begin
    logic [31:0] e;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && cpu_req && !cpu_we && !cpu_stall) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R7 unexpected load result", cpu_rdata, 0);
        end else begin
          e = sb_q.pop_front();
          chk(cpu_rdata == e, "R1 R7 load data", cpu_rdata, e);
        end
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd);
    logic [7:0]  idx;
    logic [19:0] tg;
    logic [31:0] wa;
    logic        eh;
    idx = addr[11:4];
    tg  = addr[31:12];
    wa  = {addr[31:2], 2'b00};
    eh  = ref_valid[idx] && (ref_tag[idx] == tg);
    if (!eh && ref_valid[idx] && ref_dirty[idx]) begin
      wb_exp++;
      exp_wb_addr = {ref_tag[idx], idx, 4'h0};
    end
    if (!we) sb_q.push_back(ref_rd(wa));
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    #1;
    chk(cpu_hit == eh, "R2 hit flag", cpu_hit, eh);
    chk(cpu_stall == !eh, "R5 stall on miss", cpu_stall, !eh);
    while (cpu_stall) begin
      @(negedge clk);
      #1;
    end
    if (!eh) chk(mem_ack && !mem_we, "R7 stall drops with refill ack", {mem_ack, mem_we}, 2'b10);
    @(posedge clk);
    #1;
    cpu_req = 1'b0;
    if (we) ref_word[wa] = wd;
    ref_dirty[idx] = eh ? (ref_dirty[idx] | we) : we;
    ref_valid[idx] = 1'b1;
    ref_tag[idx]   = tg;
    chk(wb_seen == wb_exp, "R3 R5 write-back count", wb_seen, wb_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ref_valid[i] = 1'b0; ref_dirty[i] = 1'b0; ref_tag[i] = '0;
    end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!cpu_stall && !mem_req, "R8 quiet in reset", {cpu_stall, mem_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cpu_stall && !mem_req, "R8 quiet after reset", {cpu_stall, mem_req}, 0);

    // R8 first access misses; R7 load miss; R6 refill installs
    access(1'b0, 32'h0000_1000, 0);
    // R1 R2 word selection on hits
    access(1'b0, 32'h0000_1004, 0);
    access(1'b0, 32'h0000_100C, 0);
    // R3 store hit, no memory traffic
    access(1'b1, 32'h0000_1008, 32'hDEAD_BEEF);
    access(1'b0, 32'h0000_1008, 0);
    // R5 dirty victim written back, then refill
    access(1'b0, 32'h0000_2000, 0);
    access(1'b0, 32'h0000_2004, 0);
    // R5 clean victim dropped; stored word comes back from memory
    access(1'b0, 32'h0000_1008, 0);
    // R4 store miss: fetch, merge, mark modified
    access(1'b1, 32'h0000_3010, 32'h1234_5678);
    access(1'b0, 32'h0000_3010, 0);
    access(1'b0, 32'h0000_3014, 0);
    access(1'b0, 32'h0000_4010, 0);
    access(1'b0, 32'h0000_3010, 0);
    // sweep over indices: stores, then conflicting loads
    for (int i = 0; i < 8; i++)
      access(1'b1, {20'h00005, i[7:0], i[1:0], 2'b00}, 32'hA000_0000 + i * 32'h111);
    for (int i = 0; i < 8; i++)
      access(1'b0, {20'h00005, i[7:0], i[1:0], 2'b00}, 0);
    for (int i = 0; i < 8; i++)
      access(1'b0, {20'h00006, i[7:0], 4'h4}, 0);
    for (int i = 0; i < 8; i++)
      access(1'b0, {20'h00005, i[7:0], i[1:0], 2'b00}, 0);
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R7 all loads returned", sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule